// File: doc/BRIEF.md
# Byte-Wide SPI Master With Register Front End

This block is a serial peripheral interface master for one byte at a time. It sits behind a four-entry register interface: a control register, a clock-rate register, a status register and a data register. Software sets the port enable, the clock polarity, the clock phase and the bit order. Writing a byte to the data register starts a frame on the serial pins. The byte received on the input line during that frame comes back through the same data register address.

The serial clock comes from the bus clock through a two-stage divisor. A 3-bit multiplier and a 4-bit power-of-two exponent set one half period of the serial clock. The slave select output goes low half a serial period before the first clock edge. It goes high half a period after the sixteenth edge. A transmit-empty flag and a receive-full flag each drive an interrupt request, and each request has its own enable. The receive-full flag only clears after a status read followed by a data read.

Register offsets on `sel_i`: 0 = control, 1 = rate, 2 = status, 3 = data. Reads are combinational on `rdata_o`. A read strobe is only needed for the side effects of a read.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, `ss_no` is 1, `sck_o` is 0, `mosi_o` is 0, both interrupt outputs are 0, and the status register reads 0x01 (bit 0 = transmit empty, bit 1 = receive full).
- R2: The control bit 3 (polarity) sets the level of `sck_o` whenever no frame is active: 0 gives a low idle level, 1 gives a high idle level.
- R3: The control bit 4 (phase) selects when each bit is sampled. With phase 0, `miso_i` is sampled on edges 1, 3, ..., 15 and `mosi_o` changes only on the other edges. With phase 1, sampling is on edges 2, 4, ..., 16. In both cases a frame has exactly 16 clock edges, and the sampled byte can be read at offset 3 afterwards.
- R4: The control bit 5 selects the bit order: 1 sends and receives the least significant bit first, 0 sends the most significant bit first.
- R5: With rate register bits 6:4 = p and bits 3:0 = r, one half serial period is H = (p+1)·2^r bus cycles. The first edge comes H cycles after `ss_no` falls, and `ss_no` stays low for 17·H cycles.
- R6: Rate field values above 7 act as 7, so rate register 0x7F gives H = 1024.
- R7: A data write with the port enabled clears transmit-empty. If no frame is running, the byte moves to the shifter on the next clock, `ss_no` falls, and transmit-empty reads 1 again one cycle after the write.
- R8: At the end of a frame, receive-full sets. It stays set through data reads until a status read that sees it set is followed by a data read.
- R9: `irq_rx_o` is receive-full gated by control bit 1. `irq_tx_o` is transmit-empty gated by control bit 2 and the enable bit 0.
- R10: With control bit 0 clear, data writes are ignored: transmit-empty stays 1, `ss_no` stays high and `sck_o` keeps its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| ss_no | output | 1 | Slave select, active low |
| miso_i | input | 1 | Serial data in |
| irq_rx_o | output | 1 | Receive-full interrupt request |
| irq_tx_o | output | 1 | Transmit-empty interrupt request |

## Verification
The checker assumes that polarity, phase, bit order and the rate register stay unchanged while `ss_no` is low. Its properties on edge placement and output stability rely on this. The bench only rewrites the control and rate registers between frames, after it has seen `ss_no` return high. The bench models the slave: it changes `miso_i` half a bus cycle after a shift edge it has observed, so the input is always stable at the next sampling edge, even at the fastest rate.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_RATE = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] spare;
    logic       lsb_first;
    logic       cpha;
    logic       cpol;
    logic       tx_ie;
    logic       rx_ie;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int CNT_W = PRE_W + RATE_MAX + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [RATE_W-1:0] rate_eff;
  logic [CNT_W-1:0]  half, cnt_q;
  logic              last;

  // exponent saturates at RATE_MAX
  assign rate_eff = (rate_i > RATE_W'(RATE_MAX)) ? RATE_W'(RATE_MAX) : rate_i;
  assign half     = (CNT_W'(pre_i) + ONE) << rate_eff;
  assign last     = (cnt_q == half - ONE);
  assign tick_o   = run_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i || last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tick_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_no
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int IW    = $clog2(DATA_W);
  localparam logic [EW-1:0] LAST_E = EW'(EDGES);

  logic              busy_q;
  logic [EW-1:0]     edge_q, tx_e;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [IW-1:0]     rx_idx, tx_idx, rx_pos, tx_pos;
  logic              sample;

  // edge_q = edges already produced in this frame
  assign sample = (edge_q[0] == cpha_i);
  assign rx_idx = IW'(edge_q >> 1);

  always_comb begin
    if (cpha_i) tx_e = (edge_q == '0) ? '0 : ((edge_q - EW'(1)) >> 1);
    else        tx_e = edge_q >> 1;
    if (tx_e > EW'(DATA_W - 1)) tx_e = EW'(DATA_W - 1);
  end
  assign tx_idx = IW'(tx_e);
  assign rx_pos = lsb_i ? rx_idx : IW'(DATA_W - 1) - rx_idx;
  assign tx_pos = lsb_i ? tx_idx : IW'(DATA_W - 1) - tx_idx;

  assign load_o    = en_i & ~busy_q & start_i;
  assign done_o    = en_i & busy_q & tick_i & (edge_q == LAST_E);
  assign busy_o    = busy_q;
  assign rx_byte_o = rx_q;
  assign sck_o     = cpol_i ^ edge_q[0];
  assign mosi_o    = busy_q & tx_q[tx_pos];
  assign ss_no     = ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      edge_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        tx_q   <= tx_byte_i;
      end
    end else if (tick_i) begin
      if (edge_q == LAST_E) begin
        busy_q <= 1'b0;
        edge_q <= '0;
      end else begin
        edge_q <= edge_q + EW'(1);
        if (sample) rx_q[rx_pos] <= miso_i;
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int PRE_W    = 3,
  parameter int RATE_W   = 4,
  parameter int RATE_MAX = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       ss_no,
  input  logic       miso_i,
  output logic       irq_rx_o,
  output logic       irq_tx_o
);
  localparam int RW = PRE_W + RATE_W;

  ctrl_t         ctrl_q;
  logic [RW-1:0] rate_q;
  logic [7:0]    tx_buf_q, rx_data_q, rx_byte;
  logic          tx_full_q, rx_full_q, rx_armed_q;
  logic          wr_data, rd_data, rd_stat, load, done, tick, busy;

  assign wr_data = wr_i & (sel_i == REG_DATA) & ctrl_q.en;
  assign rd_data = rd_i & (sel_i == REG_DATA);
  assign rd_stat = rd_i & (sel_i == REG_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rate_q <= '0;
    end else if (wr_i) begin
      if (sel_i == REG_CTRL) ctrl_q <= wdata_i;
      if (sel_i == REG_RATE) rate_q <= wdata_i[RW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q  <= '0;
      tx_full_q <= 1'b0;
    end else if (wr_data) begin
      tx_buf_q  <= wdata_i;
      tx_full_q <= 1'b1;
    end else if (load || !ctrl_q.en) begin
      tx_full_q <= 1'b0;
    end
  end

  // receive flag: status read that sees it set arms, data read then clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q  <= '0;
      rx_full_q  <= 1'b0;
      rx_armed_q <= 1'b0;
    end else if (done) begin
      rx_data_q  <= rx_byte;
      rx_full_q  <= 1'b1;
      rx_armed_q <= 1'b0;
    end else if (rd_data && rx_armed_q) begin
      rx_full_q  <= 1'b0;
      rx_armed_q <= 1'b0;
    end else if (rd_stat && rx_full_q) begin
      rx_armed_q <= 1'b1;
    end
  end

  spim_clkgen #(
    .PRE_W   (PRE_W),
    .RATE_W  (RATE_W),
    .RATE_MAX(RATE_MAX)
  ) i_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .pre_i (rate_q[RW-1:RATE_W]),
    .rate_i(rate_q[RATE_W-1:0]),
    .tick_o(tick)
  );

  spim_shifter #(
    .DATA_W(8)
  ) i_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q.en),
    .start_i  (tx_full_q),
    .tx_byte_i(tx_buf_q),
    .tick_i   (tick),
    .cpol_i   (ctrl_q.cpol),
    .cpha_i   (ctrl_q.cpha),
    .lsb_i    (ctrl_q.lsb_first),
    .miso_i   (miso_i),
    .busy_o   (busy),
    .load_o   (load),
    .done_o   (done),
    .rx_byte_o(rx_byte),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .ss_no    (ss_no)
  );

  always_comb begin
    case (sel_i)
      REG_CTRL: rdata_o = ctrl_q;
      REG_RATE: rdata_o = 8'(rate_q);
      REG_STAT: rdata_o = {6'b0, rx_full_q, ~tx_full_q};
      default:  rdata_o = rx_data_q;
    endcase
  end

  assign irq_rx_o = ctrl_q.rx_ie & rx_full_q;
  assign irq_tx_o = ctrl_q.tx_ie & ctrl_q.en & ~tx_full_q;
endmodule

// File: rtl/spim_checker.sv
module spim_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_i,
  input logic mosi_i,
  input logic ss_ni,
  input logic cpol_i,
  input logic lsb_i,
  input logic en_i,
  input logic rx_ie_i,
  input logic rx_full_i,
  input logic rd_data_i,
  input logic irq_rx_i
);
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_ni |-> (sck_i == cpol_i)); // R2

  AST_SCK_ONLY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sck_i) && $stable(cpol_i)) |-> !ss_ni); // R5

  AST_MOSI_MOVES_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_ni && $past(!ss_ni) && $stable(sck_i) && $stable(lsb_i)) |-> $stable(mosi_i)); // R3

  AST_RX_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_i && !rd_data_i) |=> rx_full_i); // R8

  AST_IRQ_RX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ie_i |-> !irq_rx_i); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> ss_ni); // R10
endmodule

bind spi_byte_master spim_checker i_spim_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_i    (sck_o),
  .mosi_i   (mosi_o),
  .ss_ni    (ss_no),
  .cpol_i   (ctrl_q.cpol),
  .lsb_i    (ctrl_q.lsb_first),
  .en_i     (ctrl_q.en),
  .rx_ie_i  (ctrl_q.rx_ie),
  .rx_full_i(rx_full_q),
  .rd_data_i(rd_i && (sel_i == 2'd3)),
  .irq_rx_i (irq_rx_o)
);

// File: tb/test_spi_byte_master.sv
`timescale 1ns/1ps
module test_spi_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       wr = 1'b0, rd = 1'b0, miso = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       sck, mosi, ss_n, irq_rx, irq_tx;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spi_byte_master i_spi_byte_master (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .ss_no(ss_n), .miso_i(miso), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tasks are entered and left just after a falling clock edge
  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    sel = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    sel = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input bit en, rxie, txie, cpol, cpha, lsb);
    return {2'b00, lsb, cpha, cpol, txie, rxie, en};
  endfunction

  // one frame; bench acts as the slave
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sb, input bit cpol,
                      input bit cpha, input bit lsb, input int h, input bit do_read);
    int cyc = 0, edges = 0, first = -1, idx;
    logic prev;
    logic [7:0] got = 8'd0, d;
    reg_wr(2'd3, tx);
    while (ss_n && cyc < 100) begin @(negedge clk); cyc++; end
    cyc = 0;
    miso = sb[lsb ? 0 : 7];
    prev = sck;
    while (!ss_n && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (sck !== prev) begin
        prev = sck;
        edges++;
        if (edges == 1) first = cyc;
        if ((edges % 2 == 1) != cpha) begin
          idx = (edges - 1) / 2;
          got[lsb ? idx : 7 - idx] = mosi;
        end else begin
          idx = cpha ? (edges - 1) / 2 : edges / 2;
          if (idx < 8) miso = sb[lsb ? idx : 7 - idx];
        end
      end
    end
    chk("R5 first edge delay", first, h);
    chk("R5 select low cycles", cyc, 17 * h);
    chk("R3 edge count", edges, 16);
    chk("R4 mosi byte in order", got, tx);
    chk("R2 sck idle after frame", sck, cpol);
    if (do_read) begin
      reg_rd(2'd2, d);
      chk("R8 receive full set", d[1], 1'b1);
      reg_rd(2'd3, d);
      chk("R3 received byte", d, sb);
      reg_rd(2'd2, d);
      chk("R8 cleared after status+data read", d[1], 1'b0);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 ss_no", ss_n, 1'b1);
    chk("R1 sck", sck, 1'b0);
    chk("R1 mosi", mosi, 1'b0);
    chk("R1 irqs", {irq_rx, irq_tx}, 2'b00);
    reg_rd(2'd2, d);
    chk("R1 status", d, 8'h01);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    bit quiet = 1'b1;
    reg_wr(2'd0, ctrl(0, 1, 1, 1, 0, 0));
    chk("R2 idle high", sck, 1'b1);
    chk("R9 irq_tx needs enable", irq_tx, 1'b0);
    reg_wr(2'd3, 8'hA5);
    for (int i = 0; i < 40; i++) begin
      if (!ss_n || !sck) quiet = 1'b0;
      @(negedge clk);
    end
    chk("R10 no frame when disabled", quiet, 1'b1);
    reg_rd(2'd2, d);
    chk("R10 write ignored, tx empty", d, 8'h01);
  endtask

  task automatic t_tx_flag;
    reg_wr(2'd1, 8'h01);
    reg_wr(2'd0, ctrl(1, 0, 0, 0, 0, 0));
    chk("R9 irq_tx off without enable", irq_tx, 1'b0);
    reg_wr(2'd0, ctrl(1, 0, 1, 0, 0, 0));
    chk("R9 irq_tx when empty", irq_tx, 1'b1);
    reg_wr(2'd3, 8'h3C);
    sel = 2'd2;
    #1;
    chk("R7 tx empty cleared by write", rdata[0], 1'b0);
    chk("R9 irq_tx low while full", irq_tx, 1'b0);
    chk("R7 frame not yet started", ss_n, 1'b1);
    @(negedge clk);
    #1;
    chk("R7 tx empty after move", rdata[0], 1'b1);
    chk("R7 select low after move", ss_n, 1'b0);
    chk("R9 irq_tx back", irq_tx, 1'b1);
    while (!ss_n) @(negedge clk);
  endtask

  task automatic t_modes;
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd0, ctrl(1, 0, 0, 0, 0, 0));
    xfer(8'hB4, 8'h6D, 0, 0, 0, 1, 1);
    reg_wr(2'd1, 8'h01);
    reg_wr(2'd0, ctrl(1, 0, 0, 0, 1, 1));
    xfer(8'h1E, 8'hC3, 0, 1, 1, 2, 1);
    reg_wr(2'd1, 8'h12);
    reg_wr(2'd0, ctrl(1, 0, 0, 1, 0, 1));
    chk("R2 idle level high", sck, 1'b1);
    xfer(8'h81, 8'h5A, 1, 0, 1, 8, 1);
    reg_wr(2'd1, 8'h30);
    reg_wr(2'd0, ctrl(1, 0, 0, 1, 1, 0));
    xfer(8'h27, 8'hE1, 1, 1, 0, 4, 1);
  endtask

  task automatic t_clamp;
    reg_wr(2'd1, 8'h7F);
    reg_wr(2'd0, ctrl(1, 0, 0, 0, 0, 0));
    xfer(8'hF0, 8'h0F, 0, 0, 0, 1024, 1); // R6
  endtask

  task automatic t_rx_clear;
    logic [7:0] d;
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd0, ctrl(1, 1, 0, 0, 0, 0));
    xfer(8'h99, 8'h4B, 0, 0, 0, 1, 0);
    chk("R9 irq_rx on full", irq_rx, 1'b1);
    reg_rd(2'd3, d);
    chk("R8 data read value", d, 8'h4B);
    chk("R8 data read alone keeps flag", irq_rx, 1'b1);
    reg_rd(2'd2, d);
    chk("R8 status shows full", d, 8'h03);
    chk("R8 status read alone keeps flag", irq_rx, 1'b1);
    reg_rd(2'd3, d);
    chk("R8 cleared by status then data", irq_rx, 1'b0);
    reg_rd(2'd2, d);
    chk("R8 status after clear", d, 8'h01);
    reg_wr(2'd0, ctrl(1, 0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_tx_flag();
    t_modes();
    t_clamp();
    t_rx_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule